// File: doc/BRIEF.md
# I2C Master Bus-Cycle Engine

This block is an I2C bus master that firmware steps through a transfer one bus cycle at a time. A write to the command port with its acknowledge-clear bit set launches exactly one cycle: a START (or repeated START), a STOP, or one byte taken from the transmit data register. When a START or byte cycle ends, the engine raises a completion flag and loads an 8-bit status code. It then holds SCL low until firmware issues the next command. A STOP returns the bus to idle and does not raise the flag.

SCL and SDA are open-drain. Each line has an output enable that pulls it low and a sampled input that reads the wire. The SCL timing comes from a bit-rate value and a two-bit prescale value. If a slave holds SCL low, the high phase is stretched. The engine does only master transmission on a single-master bus.

Top module: `i2c_cycle_master`

## Requirements
- R1: After reset both output enables are 0 (lines released), the completion flag is 0 and the status reads 0xF8.
- R2: A START command makes SDA fall while SCL is high, and then pulls SCL low. On completion, status is 0x08 if the bus was idle, or 0x10 if it was a repeated START from the held state.
- R3: A byte is shifted out most significant bit first, one bit per SCL pulse. SDA is released for a ninth pulse, and SDA low at the end of that pulse's high phase counts as an acknowledge. The first byte after a START is an address byte whose bit 0 is the direction (0 write, 1 read). Its status codes are: write acked 0x18, write not acked 0x20, read acked 0x40, read not acked 0x48.
- R4: A byte that is not the first after a START is a data byte. Its status is 0x28 when acknowledged and 0x30 when not.
- R5: A STOP command makes SDA rise while SCL is high and then waits one further half period. The engine then releases both lines and loads status 0xF8, with the flag left at 0.
- R6: The SCL high phase and low phase each last 8 + bitrate·4^prescale clock cycles, so one SCL period is 16 + 2·bitrate·4^prescale cycles.
- R7: The flag rises when a START or byte cycle completes. Any command write with the clear bit at 1 clears it. A command write with the clear bit at 0 changes nothing and launches nothing.
- R8: The command fields have a fixed priority. The start bit beats the stop bit, and the stop bit beats a byte transmission.
- R9: In idle only a START is accepted. After a not-acknowledged byte, or after an address with the read direction, a byte command is refused; only START or STOP may follow. A refused command causes no bus activity and leaves the status unchanged.
- R10: SDA changes only while SCL is low, except for the START and STOP edges.
- R11: While SCL is released but the wire still reads low (a stretching slave), the high-phase count pauses. Once the wire is released, SCL is held high for the full half period of counted cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_clr | input | 1 | Clear-flag bit of the command write; 1 launches |
| cmd_start | input | 1 | Command requests a START |
| cmd_stop | input | 1 | Command requests a STOP |
| txd_we | input | 1 | Transmit data register write strobe |
| txd_data | input | 8 | Byte to transmit |
| bitrate | input | BR_W (8) | Bit-rate value |
| prescale | input | PS_W (2) | Power-of-four prescale |
| scl_i | input | 1 | Sampled SCL wire |
| sda_i | input | 1 | Sampled SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq_flag | output | 1 | Cycle-complete flag |
| status | output | 8 | Status code, code in bits 7:3 |

## Verification
The bench targets the edges of the handshake. A byte command is sent in idle, after a not-acknowledged byte and after a read address; a design that fails to refuse it would toggle SCL, which the scoreboard reports as an unexpected bus event. The bench also writes a command with the clear bit at 0 and sends start and stop together. A wrong priority would show up as a STOP, or as a lost flag.

Status codes are checked for a START from idle versus a repeated START, and for the address and data phases with and without acknowledge. A design that loses track of the first byte would report 0x28 where 0x18 belongs. SCL phase lengths are measured at three bit-rate and prescale settings, and again after a slave stretches the clock. A shift error in the prescale, or a counter that keeps running during a stretch, changes the counted width.

// File: rtl/i2c_cyc_pkg.sv
package i2c_cyc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // bus free, lines released
    ST_HELD,   // bus owned, SCL held low, waiting for a command
    ST_SREL,   // repeated start: release SDA with SCL low
    ST_SSET,   // start setup: both lines high
    ST_SFALL,  // start edge: SDA low with SCL high
    ST_SLOW,   // start hold: SCL pulled low
    ST_BLOW,   // bit slot, SCL low
    ST_BHIGH,  // bit slot, SCL high
    ST_PLOW,   // stop: SDA low with SCL low
    ST_PHIGH,  // stop: SCL high, SDA low
    ST_PFREE   // stop edge and bus free time
  } seq_state_e;

  localparam logic [7:0] CODE_START    = 8'h08;
  localparam logic [7:0] CODE_RESTART  = 8'h10;
  localparam logic [7:0] CODE_AW_ACK   = 8'h18;
  localparam logic [7:0] CODE_AW_NACK  = 8'h20;
  localparam logic [7:0] CODE_D_ACK    = 8'h28;
  localparam logic [7:0] CODE_D_NACK   = 8'h30;
  localparam logic [7:0] CODE_AR_ACK   = 8'h40;
  localparam logic [7:0] CODE_AR_NACK  = 8'h48;
  localparam logic [7:0] CODE_NONE     = 8'hF8;

endpackage

// File: rtl/i2c_cyc_brg.sv
// Half-period tick generator: a tick ends each SCL half period.
module i2c_cyc_brg #(
  parameter int BR_W = 8,
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            stall,
  input  logic [BR_W-1:0] bitrate,
  input  logic [PS_W-1:0] prescale,
  output logic            tick
);
  localparam int MAX_SH = 2 * ((1 << PS_W) - 1);
  localparam int HW     = BR_W + MAX_SH + 1;

  logic [HW-1:0] half;
  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    half = HW'(8) + (HW'(bitrate) << {prescale, 1'b0});
  end

  always_comb begin
    tick  = run && !stall && (cnt_q == half - HW'(1));
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (!stall) begin
      if (tick) cnt_d = '0;
      else      cnt_d = cnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_cyc_shift.sv
// Transmit shifter: MSB first, fills with ones so the ack slot is released.
module i2c_cyc_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          bit_out,
  output logic          rw_bit
);
  logic [DW-1:0] sh_q, sh_d;
  logic          rw_q, rw_d;

  always_comb begin
    sh_d = sh_q;
    rw_d = rw_q;
    if (load) begin
      sh_d = din;
      rw_d = din[0];
    end else if (shift) begin
      sh_d = {sh_q[DW-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
      rw_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      rw_q <= rw_d;
    end
  end

  assign bit_out = sh_q[DW-1];
  assign rw_bit  = rw_q;
endmodule

// File: rtl/i2c_cyc_seq.sv
// Bus-cycle sequencer: walks the half-period slots of one commanded cycle.
module i2c_cyc_seq
  import i2c_cyc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       go_start,
  input  logic       go_stop,
  input  logic       tick,
  input  logic       bit_out,
  input  logic       rw_bit,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       load,
  output logic       shift,
  output logic       run,
  output logic       stall,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       done,
  output logic       stopped,
  output logic [7:0] done_code,
  output seq_state_e state
);
  localparam int IW = $clog2(DW + 1);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          addr_q, addr_d;   // next byte is the address byte
  logic          lock_q, lock_d;   // byte commands refused
  logic          rep_q, rep_d;     // start launched from held bus
  logic          sda_q, sda_d;     // SDA drive, one cycle behind SCL
  logic          ack;
  logic          scl_free;

  assign ack = !sda_i;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    addr_d    = addr_q;
    lock_d    = lock_q;
    rep_d     = rep_q;
    load      = 1'b0;
    shift     = 1'b0;
    done      = 1'b0;
    stopped   = 1'b0;
    done_code = CODE_NONE;
    case (state_q)
      ST_IDLE: begin
        if (go && go_start) begin
          rep_d   = 1'b0;
          state_d = ST_SSET;
        end
      end
      ST_HELD: begin
        if (go) begin
          if (go_start) begin
            rep_d   = 1'b1;
            state_d = ST_SREL;
          end else if (go_stop) begin
            state_d = ST_PLOW;
          end else if (!lock_q) begin
            load    = 1'b1;
            idx_d   = '0;
            state_d = ST_BLOW;
          end
        end
      end
      ST_SREL:  if (tick) state_d = ST_SSET;
      ST_SSET:  if (tick) state_d = ST_SFALL;
      ST_SFALL: if (tick) state_d = ST_SLOW;
      ST_SLOW: begin
        if (tick) begin
          done      = 1'b1;
          done_code = rep_q ? CODE_RESTART : CODE_START;
          addr_d    = 1'b1;
          lock_d    = 1'b0;
          state_d   = ST_HELD;
        end
      end
      ST_BLOW:  if (tick) state_d = ST_BHIGH;
      ST_BHIGH: begin
        if (tick) begin
          if (idx_q == IW'(DW)) begin
            done = 1'b1;
            if (addr_q) begin
              if (rw_bit) done_code = ack ? CODE_AR_ACK : CODE_AR_NACK;
              else        done_code = ack ? CODE_AW_ACK : CODE_AW_NACK;
            end else begin
              done_code = ack ? CODE_D_ACK : CODE_D_NACK;
            end
            lock_d  = !ack || (addr_q && rw_bit);
            addr_d  = 1'b0;
            state_d = ST_HELD;
          end else begin
            shift   = 1'b1;
            idx_d   = idx_q + IW'(1);
            state_d = ST_BLOW;
          end
        end
      end
      ST_PLOW:  if (tick) state_d = ST_PHIGH;
      ST_PHIGH: if (tick) state_d = ST_PFREE;
      ST_PFREE: begin
        if (tick) begin
          stopped = 1'b1;
          addr_d  = 1'b0;
          lock_d  = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    scl_free = 1'b0;
    sda_d    = 1'b0;
    case (state_q)
      ST_SSET, ST_SFALL, ST_BHIGH, ST_PHIGH, ST_PFREE: scl_free = 1'b1;
      default: scl_free = 1'b0;
    endcase
    case (state_q)
      ST_HELD, ST_SFALL, ST_SLOW, ST_PLOW, ST_PHIGH: sda_d = 1'b1;
      ST_BLOW, ST_BHIGH: sda_d = !bit_out;
      default: sda_d = 1'b0;
    endcase
  end

  assign run    = (state_q != ST_IDLE) && (state_q != ST_HELD);
  assign stall  = scl_free && !scl_i;
  assign scl_oe = run ? !scl_free : (state_q == ST_HELD);
  assign sda_oe = sda_q;
  assign state  = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      addr_q  <= 1'b0;
      lock_q  <= 1'b0;
      rep_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      lock_q  <= lock_d;
      rep_q   <= rep_d;
      sda_q   <= sda_d;
    end
  end
endmodule

// File: rtl/i2c_cycle_master.sv
module i2c_cycle_master
  import i2c_cyc_pkg::*;
#(
  parameter int BR_W = 8,
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic            cmd_clr,
  input  logic            cmd_start,
  input  logic            cmd_stop,
  input  logic            txd_we,
  input  logic [7:0]      txd_data,
  input  logic [BR_W-1:0] bitrate,
  input  logic [PS_W-1:0] prescale,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            irq_flag,
  output logic [7:0]      status
);
  localparam int DW = 8;

  logic          go;
  logic          tick, run, stall, load, shift;
  logic          bit_out, rw_bit;
  logic          done, stopped;
  logic [7:0]    done_code;
  seq_state_e    seq_state;

  logic [DW-1:0] txd_q, txd_d;
  logic          flag_q, flag_d;
  logic [7:0]    stat_q, stat_d;

  assign go = cmd_we && cmd_clr;

  i2c_cyc_brg #(.BR_W(BR_W), .PS_W(PS_W)) brg_i (
    .clk(clk), .rst_n(rst_n), .run(run), .stall(stall),
    .bitrate(bitrate), .prescale(prescale), .tick(tick)
  );

  i2c_cyc_shift #(.DW(DW)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .din(txd_q), .bit_out(bit_out), .rw_bit(rw_bit)
  );

  i2c_cyc_seq #(.DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .go_start(cmd_start), .go_stop(cmd_stop),
    .tick(tick), .bit_out(bit_out), .rw_bit(rw_bit), .scl_i(scl_i), .sda_i(sda_i),
    .load(load), .shift(shift), .run(run), .stall(stall),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .stopped(stopped),
    .done_code(done_code), .state(seq_state)
  );

  always_comb begin
    txd_d  = txd_we ? txd_data : txd_q;
    flag_d = flag_q;
    if (done)    flag_d = 1'b1;
    else if (go) flag_d = 1'b0;
    stat_d = stat_q;
    if (done)         stat_d = done_code;
    else if (stopped) stat_d = CODE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q  <= '0;
      flag_q <= 1'b0;
      stat_q <= CODE_NONE;
    end else begin
      txd_q  <= txd_d;
      flag_q <= flag_d;
      stat_q <= stat_d;
    end
  end

  assign irq_flag = flag_q;
  assign status   = stat_q;
endmodule

// File: rtl/i2c_cycle_master_chk.sv
module i2c_cycle_master_chk
  import i2c_cyc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq_flag,
  input logic [7:0] status,
  input seq_state_e state
);
  p_idle_scl_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !scl_oe);

  p_start_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_SLOW && state == ST_HELD) |-> (status == CODE_START || status == CODE_RESTART));

  p_stop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_PFREE && state == ST_IDLE) |-> (!irq_flag && status == CODE_NONE));

  p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (state == ST_HELD && $past(state) != ST_HELD));

  p_flag_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag |-> (state == ST_HELD));

  p_sda_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe)) |-> (state == ST_SFALL || state == ST_PFREE));
endmodule

bind i2c_cycle_master i2c_cycle_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq_flag(irq_flag), .status(status), .state(seq_state)
);

// File: tb/i2c_cycle_master_tb_top.sv
module i2c_cycle_master_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, cmd_we, cmd_clr, cmd_start, cmd_stop, txd_we;
  logic [7:0] txd_data, bitrate, status;
  logic [1:0] prescale;
  logic       scl_oe, sda_oe, irq_flag;
  logic       slv_sda_low, slv_scl_hold, ack_en;
  logic       scl_w, sda_w;

  assign scl_w = !(scl_oe || slv_scl_hold);
  assign sda_w = !(sda_oe || slv_sda_low);

  i2c_cycle_master dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_clr(cmd_clr),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .txd_we(txd_we), .txd_data(txd_data),
    .bitrate(bitrate), .prescale(prescale), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq_flag(irq_flag), .status(status)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    ended = 0;
  int    exp_q[$];
  string req_q[$];

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: 0..255 byte, 256 START, 257 STOP
  task automatic expect_ev(int ev, string req);
    exp_q.push_back(ev);
    req_q.push_back(req);
  endtask

  task automatic got(int ev);
    if (exp_q.size() == 0) chk("R9", "unexpected bus event", ev, -1);
    else chk(req_q.pop_front(), "bus event", ev, exp_q.pop_front());
  endtask

  // bus monitor and acknowledging slave
  int         bitcnt = 0;
  logic [7:0] shreg;
  always @(posedge scl_w) begin
    if (bitcnt < 8) begin
      shreg = {shreg[6:0], sda_w};
      bitcnt++;
      if (bitcnt == 8) got(int'(shreg));
    end else begin
      bitcnt = 0;
    end
  end
  always @(negedge scl_w) begin
    if (bitcnt == 8 && ack_en) begin
      #20 slv_sda_low = 1'b1;
    end else if (bitcnt == 0 && slv_sda_low) begin
      #20 slv_sda_low = 1'b0;
    end
  end
  always @(negedge sda_w) if (scl_w) begin got(256); bitcnt = 0; end
  always @(posedge sda_w) if (scl_w) begin got(257); bitcnt = 0; end

  // driver tasks
  task automatic cmd(bit st, bit sp, bit clr);
    @(negedge clk);
    cmd_we = 1'b1; cmd_clr = clr; cmd_start = st; cmd_stop = sp;
    @(negedge clk);
    cmd_we = 1'b0; cmd_clr = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
  endtask

  task automatic wait_flag(string req);
    int n = 0;
    while (!irq_flag && n < 5000) begin @(negedge clk); n++; end
    chk(req, "flag set", int'(irq_flag), 1);
  endtask

  function automatic int half(int br, int ps);
    return 8 + br * (1 << (2 * ps));
  endfunction

  task automatic do_start(bit stop_too, int code, string req);
    expect_ev(256, req);
    cmd(1'b1, stop_too, 1'b1);
    wait_flag(req);
    chk(req, "start status", int'(status), code);
  endtask

  task automatic load_byte(logic [7:0] b);
    @(negedge clk); txd_we = 1'b1; txd_data = b;
    @(negedge clk); txd_we = 1'b0;
  endtask

  task automatic do_byte(logic [7:0] b, bit ack, int code, string req, int h_exp);
    int hi, lo;
    load_byte(b);
    ack_en = ack;
    expect_ev(int'(b), req);
    cmd(1'b0, 1'b0, 1'b1);
    if (h_exp > 0) begin
      while (scl_oe != 1'b0) @(negedge clk);
      hi = 0;
      while (scl_oe == 1'b0) begin hi++; @(negedge clk); end
      lo = 0;
      while (scl_oe == 1'b1) begin lo++; @(negedge clk); end
      chk("R6", "scl high cycles", hi, h_exp);
      chk("R6", "scl low cycles", lo, h_exp);
    end
    wait_flag(req);
    chk(req, "byte status", int'(status), code);
  endtask

  // command that must be refused: nothing moves for several half periods
  task automatic refused(bit st, bit clr, int scl_lvl, int code, string req);
    int moved = 0;
    cmd(st, 1'b0, clr);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (int'(scl_oe) != scl_lvl) moved = 1;
    end
    chk(req, "scl untouched", moved, 0);
    chk(req, "status kept", int'(status), code);
  endtask

  task automatic do_stop(string req, int h);
    expect_ev(257, req);
    cmd(1'b0, 1'b1, 1'b1);
    repeat (4 * h) @(negedge clk);
    chk(req, "flag after stop", int'(irq_flag), 0);
    chk(req, "status after stop", int'(status), 8'hF8);
    chk(req, "scl released", int'(scl_oe), 0);
    chk(req, "sda released", int'(sda_oe), 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    rst_n = 1'b0; cmd_we = 0; cmd_clr = 0; cmd_start = 0; cmd_stop = 0;
    txd_we = 0; txd_data = '0; bitrate = '0; prescale = '0;
    slv_sda_low = 0; slv_scl_hold = 0; ack_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "scl_oe", int'(scl_oe), 0);
    chk("R1", "sda_oe", int'(sda_oe), 0);
    chk("R1", "flag", int'(irq_flag), 0);
    chk("R1", "status", int'(status), 8'hF8);

    // R9 byte command in idle refused; R7 start without clear bit ignored
    load_byte(8'hFF);
    refused(1'b0, 1'b1, 0, 8'hF8, "R9");
    refused(1'b1, 1'b0, 0, 8'hF8, "R7");
    chk("R7", "flag stays 0", int'(irq_flag), 0);

    // R2 start from idle, R3 address write acked, R6 at H=8
    do_start(1'b0, 8'h08, "R2");
    do_byte(8'hA4, 1'b1, 8'h18, "R3", half(0, 0));

    // R7 write without clear bit keeps flag and launches nothing
    refused(1'b1, 1'b0, 1, 8'h18, "R7");
    chk("R7", "flag kept", int'(irq_flag), 1);

    // R4 data acked, then other rates (R6), then data not acked
    do_byte(8'h5A, 1'b1, 8'h28, "R4", 0);
    bitrate = 8'd3; prescale = 2'd1;
    do_byte(8'h81, 1'b1, 8'h28, "R4", half(3, 1));
    bitrate = 8'd1; prescale = 2'd2;
    do_byte(8'h3E, 1'b0, 8'h30, "R4", half(1, 2));
    bitrate = 8'd0; prescale = 2'd0;

    // R9 byte refused after a missing acknowledge
    refused(1'b0, 1'b1, 1, 8'h30, "R9");
    chk("R7", "flag cleared by clear bit", int'(irq_flag), 0);

    // R2 repeated start, R3 read address acked, R9 byte refused after read
    do_start(1'b0, 8'h10, "R2");
    do_byte(8'h55, 1'b1, 8'h40, "R3", 0);
    refused(1'b0, 1'b1, 1, 8'h40, "R9");

    // R8 start and stop together give a repeated start
    do_start(1'b1, 8'h10, "R8");
    do_byte(8'h3C, 1'b0, 8'h20, "R3", 0);
    // R8 stop beats byte (data register non-empty), R5 stop behaviour
    do_stop("R5", half(0, 0));

    // R11 clock stretching on an address byte
    do_start(1'b0, 8'h08, "R2");
    load_byte(8'h10);
    ack_en = 1'b1;
    expect_ev(8'h10, "R11");
    slv_scl_hold = 1'b1;
    cmd(1'b0, 1'b0, 1'b1);
    repeat (3 * half(0, 0)) @(negedge clk);
    slv_scl_hold = 1'b0;
    cnt = 0;
    @(negedge clk);
    while (scl_oe == 1'b0) begin cnt++; @(negedge clk); end
    chk("R11", "high after stretch", cnt, half(0, 0) - 1);
    wait_flag("R11");
    chk("R3", "stretched address status", int'(status), 8'h18);
    do_byte(8'hC3, 1'b1, 8'h28, "R4", 0);
    do_stop("R5", half(0, 0));

    repeat (20) @(negedge clk);
    chk("R3", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule